// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit channels between serial time-division-multiplexed streams. It has two serial data inputs and two serial data outputs. Each frame carries 32 channels per stream. The line clock runs at twice the bit rate, so one bit spans two clock cycles and one frame spans 512 cycles. A one-cycle frame strobe marks position zero of every frame.

Every received byte is written into a double-buffered data memory. The connect memory holds one entry per output channel. An entry says which input stream and channel feed that output slot, and whether the slot is driven at all. All data therefore passes from any input channel to any output channel with a fixed delay of one frame.

The connect memory is not loaded from a processor bus. It is loaded from two serial control inputs that share the data timing: the byte that arrives in channel n of control input s becomes the entry for channel n of output s. A global output-enable input can silence both outputs. Each output has its own drive-enable pin, so the pad or the bus fabric can tristate the line slot by slot.

Top module: `tsi_switch`

## Requirements
- R1: After reset and before the first frame strobe, `ser_oe` and `ser_out` stay low. Nothing arriving on `data_in` or `ctrl_in` in that time is stored.
- R2: The cycle in which `frame_sync` is high is frame position 0, and a frame lasts 512 cycles. Channel c occupies positions 16c to 16c+15. Bit i of the channel (i = 0 is the MSB) occupies positions 16c+2i and 16c+2i+1.
- R3: Each input bit is sampled in the second cycle of its two-cycle bit slot, MSB first, on both data and control inputs.
- R4: Each output bit, MSB first, holds the same value and the same drive state across both cycles of its bit slot.
- R5: When output s drives channel c of frame k, it sends the byte received in frame k-1 on input stream E[5], channel E[4:0]. E is the connect entry for (s, c).
- R6: The control byte received in channel n of `ctrl_in[s]` becomes the connect entry for output s, channel n. It first governs that output slot in the following frame.
- R7: An entry whose bit 7 is 0 leaves its slot undriven (`ser_oe` low). Entry bit 6 has no effect.
- R8: While `glob_oe` is low, no output is driven. `ser_out` is low in every cycle in which its `ser_oe` is low.
- R9: Reset disables every connect entry and clears the data memory, so the first frame after a reset drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, two cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High for one cycle at frame position 0 |
| glob_oe | input | 1 | Global drive enable for both outputs |
| data_in | input | 2 | Serial data inputs, one bit per stream |
| ctrl_in | input | 2 | Serial control inputs that load the connect entries |
| ser_out | output | 2 | Serial data outputs |
| ser_oe | output | 2 | Per-output drive enable, slot by slot |

## Verification
The hardest case to reach from the ports is the handover between connect entries. An entry changes at the end of its own slot, in the same cycle that later slots of the current frame still depend on older entries. The last channel's control byte also lands on the edge where the data banks swap. To reach these cases, the stimulus rewrites every entry in every frame with a different map: identity, crossed and reversed, hashed with random enable and don't-care bits, all off, and a broadcast of one source. A reference model checks each bit slot of every output against the map that was written one frame earlier. Frames with the global enable low, and a reset in the middle of the run, show that no stale entry leaks through.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
   // Connect entry layout; the neighbouring logic decodes these fields
   localparam int ENTRY_W = 8;
   localparam int EN_BIT  = 7;
   localparam int SRC_LSB = 5;
endpackage

// File: rtl/tsi_frame_timer.sv
`timescale 1ns/1ps
module tsi_frame_timer #(
   parameter int CH_W      = 5,
   parameter int BIT_W     = 3,
   parameter int PH_W      = 1,
   parameter int SAMPLE_PH = 1,
   localparam int POS_W    = CH_W + BIT_W + PH_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_sync,
   output logic             active,
   output logic [CH_W-1:0]  slot,
   output logic [BIT_W-1:0] bit_idx,
   output logic             sample_en,
   output logic             byte_done,
   output logic             wr_bank,
   output logic             rd_bank
);
   logic [POS_W-1:0] cnt_q;
   logic [POS_W-1:0] pos;
   logic [PH_W-1:0]  phase;
   logic             synced_q;
   logic             bank_q;

   // the strobe cycle is position zero, whatever the counter holds
   assign pos     = frame_sync ? '0 : cnt_q;
   assign slot    = pos[POS_W-1 -: CH_W];
   assign bit_idx = pos[PH_W +: BIT_W];
   assign phase   = pos[PH_W-1:0];
   assign active  = synced_q | frame_sync;

   assign sample_en = active && (phase == PH_W'(SAMPLE_PH));
   assign byte_done = sample_en && (&bit_idx);
   assign wr_bank   = bank_q;
   assign rd_bank   = ~bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         synced_q <= 1'b0;
         bank_q   <= 1'b0;
      end else begin
         cnt_q <= pos + POS_W'(1);
         if (frame_sync) synced_q <= 1'b1;
         if (active && (&pos)) bank_q <= ~bank_q;
      end
   end
endmodule

// File: rtl/tsi_serial_rx.sv
`timescale 1ns/1ps
module tsi_serial_rx #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   output logic [BYTE_W-1:0] byte_o
);
   logic [BYTE_W-2:0] sh_q;

   // the newest bit completes the byte in the same cycle it is sampled
   assign byte_o = {sh_q, din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh_q <= '0;
      else if (shift_en) sh_q <= {sh_q[BYTE_W-3:0], din};
   end
endmodule

// File: rtl/tsi_data_mem.sv
`timescale 1ns/1ps
module tsi_data_mem #(
   parameter int N_STREAMS = 2,
   parameter int N_CH      = 32,
   parameter int BYTE_W    = 8,
   localparam int STR_W    = $clog2(N_STREAMS),
   localparam int CH_W     = $clog2(N_CH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic                              wr_bank,
   input  logic [CH_W-1:0]                   wr_ch,
   input  logic [N_STREAMS-1:0][BYTE_W-1:0]  wr_byte,
   input  logic                              rd_bank,
   input  logic [N_STREAMS-1:0][STR_W-1:0]   rd_src,
   input  logic [N_STREAMS-1:0][CH_W-1:0]    rd_ch,
   output logic [N_STREAMS-1:0][BYTE_W-1:0]  rd_byte
);
   logic [BYTE_W-1:0] mem_q [2][N_STREAMS][N_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++)
            for (int s = 0; s < N_STREAMS; s++)
               for (int c = 0; c < N_CH; c++)
                  mem_q[b][s][c] <= '0;
      end else if (we) begin
         for (int s = 0; s < N_STREAMS; s++)
            mem_q[wr_bank][s][wr_ch] <= wr_byte[s];
      end
   end

   always_comb begin
      for (int o = 0; o < N_STREAMS; o++)
         rd_byte[o] = mem_q[rd_bank][rd_src[o]][rd_ch[o]];
   end
endmodule

// File: rtl/tsi_connect_mem.sv
`timescale 1ns/1ps
module tsi_connect_mem #(
   parameter int N_STREAMS = 2,
   parameter int N_CH      = 32,
   parameter int ENTRY_W   = 8,
   localparam int CH_W     = $clog2(N_CH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [CH_W-1:0]                   ch,
   input  logic [N_STREAMS-1:0][ENTRY_W-1:0] wr_entry,
   output logic [N_STREAMS-1:0][ENTRY_W-1:0] rd_entry
);
   logic [ENTRY_W-1:0] cm_q [N_STREAMS][N_CH];

   // an entry is written on the last edge of its own slot, so it
   // governs that slot only from the next frame onward
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < N_STREAMS; s++)
            for (int c = 0; c < N_CH; c++)
               cm_q[s][c] <= '0;
      end else if (we) begin
         for (int s = 0; s < N_STREAMS; s++)
            cm_q[s][ch] <= wr_entry[s];
      end
   end

   always_comb begin
      for (int s = 0; s < N_STREAMS; s++)
         rd_entry[s] = cm_q[s][ch];
   end
endmodule

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch #(
   parameter int N_STREAMS   = 2,
   parameter int N_CH        = 32,
   parameter int BYTE_W      = 8,
   parameter int CLK_PER_BIT = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_sync,
   input  logic                 glob_oe,
   input  logic [N_STREAMS-1:0] data_in,
   input  logic [N_STREAMS-1:0] ctrl_in,
   output logic [N_STREAMS-1:0] ser_out,
   output logic [N_STREAMS-1:0] ser_oe
);
   import tsi_pkg::*;

   localparam int CH_W      = $clog2(N_CH);
   localparam int BIT_W     = $clog2(BYTE_W);
   localparam int PH_W      = $clog2(CLK_PER_BIT);
   localparam int STR_W     = $clog2(N_STREAMS);
   localparam int SAMPLE_PH = (CLK_PER_BIT * 3) / 4;

   // elaboration-time parameter checks
   if ((1 << CH_W) != N_CH)               begin : g_bad_ch   $error("N_CH must be a power of two");        end
   if ((1 << BIT_W) != BYTE_W)            begin : g_bad_byte $error("BYTE_W must be a power of two");      end
   if ((1 << PH_W) != CLK_PER_BIT)        begin : g_bad_ph   $error("CLK_PER_BIT must be a power of two"); end
   if (CLK_PER_BIT < 2)                   begin : g_bad_cpb  $error("CLK_PER_BIT must be at least 2");     end
   if (N_STREAMS < 2 || (1 << STR_W) != N_STREAMS)
                                          begin : g_bad_str  $error("N_STREAMS must be a power of two >= 2"); end
   if (CH_W > SRC_LSB)                    begin : g_bad_cfld $error("channel field overlaps source field"); end
   if (SRC_LSB + STR_W > EN_BIT)          begin : g_bad_sfld $error("source field overlaps enable bit");    end
   if (BYTE_W < ENTRY_W)                  begin : g_bad_ctl  $error("control byte narrower than entry");    end

   logic                                 active;
   logic [CH_W-1:0]                      slot;
   logic [BIT_W-1:0]                     bit_idx;
   logic                                 sample_en;
   logic                                 byte_done;
   logic                                 wr_bank;
   logic                                 rd_bank;
   logic [N_STREAMS-1:0][BYTE_W-1:0]     d_byte;
   logic [N_STREAMS-1:0][BYTE_W-1:0]     c_byte;
   logic [N_STREAMS-1:0][ENTRY_W-1:0]    c_entry;
   logic [N_STREAMS-1:0][ENTRY_W-1:0]    entry;
   logic [N_STREAMS-1:0][STR_W-1:0]      src;
   logic [N_STREAMS-1:0][CH_W-1:0]       sch;
   logic [N_STREAMS-1:0][BYTE_W-1:0]     rd_byte;
   logic                                 unused_bits;

   tsi_frame_timer #(
      .CH_W(CH_W), .BIT_W(BIT_W), .PH_W(PH_W), .SAMPLE_PH(SAMPLE_PH)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
      .active(active), .slot(slot), .bit_idx(bit_idx),
      .sample_en(sample_en), .byte_done(byte_done),
      .wr_bank(wr_bank), .rd_bank(rd_bank)
   );

   for (genvar s = 0; s < N_STREAMS; s++) begin : g_lane
      tsi_serial_rx #(.BYTE_W(BYTE_W)) u_data_rx (
         .clk(clk), .rst_n(rst_n), .shift_en(sample_en),
         .din(data_in[s]), .byte_o(d_byte[s])
      );
      tsi_serial_rx #(.BYTE_W(BYTE_W)) u_ctrl_rx (
         .clk(clk), .rst_n(rst_n), .shift_en(sample_en),
         .din(ctrl_in[s]), .byte_o(c_byte[s])
      );
      assign c_entry[s] = c_byte[s][ENTRY_W-1:0];
      assign src[s]     = entry[s][SRC_LSB +: STR_W];
      assign sch[s]     = entry[s][CH_W-1:0];
      // MSB first: bit index i selects byte bit BYTE_W-1-i
      assign ser_oe[s]  = active & glob_oe & entry[s][EN_BIT];
      assign ser_out[s] = ser_oe[s] & rd_byte[s][~bit_idx];
   end

   tsi_data_mem #(
      .N_STREAMS(N_STREAMS), .N_CH(N_CH), .BYTE_W(BYTE_W)
   ) u_dmem (
      .clk(clk), .rst_n(rst_n), .we(byte_done),
      .wr_bank(wr_bank), .wr_ch(slot), .wr_byte(d_byte),
      .rd_bank(rd_bank), .rd_src(src), .rd_ch(sch), .rd_byte(rd_byte)
   );

   tsi_connect_mem #(
      .N_STREAMS(N_STREAMS), .N_CH(N_CH), .ENTRY_W(ENTRY_W)
   ) u_cmem (
      .clk(clk), .rst_n(rst_n), .we(byte_done), .ch(slot),
      .wr_entry(c_entry), .rd_entry(entry)
   );

   // entry don't-care bits and surplus control bits are intentionally dropped
   assign unused_bits = ^{entry, c_byte};
endmodule

// File: rtl/tsi_switch_chk.sv
`timescale 1ns/1ps
module tsi_switch_chk #(
   parameter int N_STREAMS   = 2,
   parameter int N_CH        = 32,
   parameter int BYTE_W      = 8,
   parameter int CLK_PER_BIT = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 frame_sync,
   input logic                 glob_oe,
   input logic [N_STREAMS-1:0] ser_out,
   input logic [N_STREAMS-1:0] ser_oe
);
   localparam int PH_W   = $clog2(CLK_PER_BIT);
   localparam int SLOT_W = PH_W + $clog2(BYTE_W);
   localparam int POS_W  = SLOT_W + $clog2(N_CH);

   logic [POS_W-1:0] c_cnt_q;
   logic [POS_W-1:0] c_pos;
   logic             seen_q;

   assign c_pos = frame_sync ? '0 : c_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_cnt_q <= '0;
         seen_q  <= 1'b0;
      end else begin
         c_cnt_q <= c_pos + POS_W'(1);
         if (frame_sync) seen_q <= 1'b1;
      end
   end

   p_idle_before_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_q && !frame_sync) |-> (ser_oe == '0));

   p_global_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_oe |-> (ser_oe == '0));

   p_quiet_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ser_out & ~ser_oe) == '0));

   p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && (c_pos[PH_W-1:0] != '0) && $stable(glob_oe))
      |-> ($stable(ser_out) && $stable(ser_oe)));

   p_slot_drive_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && (c_pos[SLOT_W-1:0] != '0) && $stable(glob_oe))
      |-> $stable(ser_oe));
endmodule

bind tsi_switch tsi_switch_chk #(
   .N_STREAMS(N_STREAMS), .N_CH(N_CH), .BYTE_W(BYTE_W), .CLK_PER_BIT(CLK_PER_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .glob_oe(glob_oe),
   .ser_out(ser_out), .ser_oe(ser_oe)
);

// File: tb/tsi_switch_tb.sv
`timescale 1ns/1ps
module tsi_switch_tb;
   localparam int NS = 2, NC = 32, BW = 8, CPB = 2;
   localparam int FRAME = NC * BW * CPB;
   localparam int NVEC = 9;
   // vector: {glob_oe[11], map kind[10:8], seed[7:0]}
   localparam logic [11:0] VEC [NVEC] = '{
      12'h800, 12'h913, 12'hA27, 12'h555, 12'hC3C,
      12'hB00, 12'hD6A, 12'hA81, 12'h800 };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_sync = 1'b0;
   logic glob_oe = 1'b0;
   logic [NS-1:0] data_in = '0;
   logic [NS-1:0] ctrl_in = '0;
   logic [NS-1:0] ser_out;
   logic [NS-1:0] ser_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] din_b [NS][NC];
   logic [7:0] ctl_b [NS][NC];
   logic [7:0] prev_d [NS][NC];
   logic [7:0] cm_m [NS][NC];

   always #2.5 clk = ~clk;

   tsi_switch #(.N_STREAMS(NS), .N_CH(NC), .BYTE_W(BW), .CLK_PER_BIT(CPB)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .glob_oe(glob_oe),
      .data_in(data_in), .ctrl_in(ctrl_in), .ser_out(ser_out), .ser_oe(ser_oe)
   );

   function automatic logic [7:0] mix(int seed, int s, int c);
      int v;
      v = seed * 131 + s * 977 + c * 29 + 7;
      v = v ^ (v >> 3) ^ (c * c * 11);
      return v[7:0];
   endfunction

   // entry: bit7 enable, bit6 ignored, bit5 source stream, bits4:0 source channel
   function automatic logic [7:0] make_entry(int kind, int seed, int s, int c);
      logic [7:0] r;
      r = mix(seed + 1, s, c);
      case (kind)
         0:       return 8'h80 | 8'(s << 5) | 8'(c);
         1:       return 8'h80 | 8'((1 - s) << 5) | 8'(31 - c);
         2:       return r;
         3:       return r & 8'h7F;
         4:       return 8'hA7;
         default: return r | 8'h80;
      endcase
   endfunction

   task automatic clear_model();
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < NC; c++) begin
            prev_d[s][c] = 8'h00;
            cm_m[s][c]   = 8'h00;
         end
   endtask

   // R2 R3 R4 R5 R6 R7 R8: one frame driven and compared bit slot by bit slot
   task automatic run_frame(input logic oe, input int kind, input int seed);
      logic [NS-1:0] bad;
      logic [NS-1:0] got_oe, got_out, exp_oe, exp_out;
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < NC; c++) begin
            din_b[s][c] = mix(seed + 40, s, c);
            ctl_b[s][c] = make_entry(kind, seed, s, c);
         end
      bad = '0;
      for (int p = 0; p < FRAME; p++) begin
         int ch, b;
         ch = p / 16;
         b  = (p / 2) % 8;
         @(posedge clk); #1;
         frame_sync = (p == 0);
         glob_oe    = oe;
         for (int s = 0; s < NS; s++) begin
            data_in[s] = din_b[s][ch][7 - b];
            ctrl_in[s] = ctl_b[s][ch][7 - b];
         end
         @(negedge clk);
         for (int s = 0; s < NS; s++) begin
            logic [7:0] e;
            e = cm_m[s][ch];
            exp_oe[s]  = oe & e[7];
            exp_out[s] = exp_oe[s] & prev_d[e[5]][e[4:0]][7 - b];
            got_oe[s]  = ser_oe[s];
            got_out[s] = ser_out[s];
            if (got_oe[s] !== exp_oe[s] || got_out[s] !== exp_out[s]) begin
               if (!bad[s])
                  $display("FAIL %s stream %0d ch %0d bit %0d: oe/out actual %b/%b expected %b/%b",
                           !oe ? "R8" : (!e[7] ? "R7" : "R5"), s, ch, b,
                           got_oe[s], got_out[s], exp_oe[s], exp_out[s]);
               bad[s] = 1'b1;
            end
         end
         if (p % 16 == 15) begin
            for (int s = 0; s < NS; s++) begin
               checks++;
               if (bad[s]) failures++;
            end
            bad = '0;
         end
      end
      // R6: entries written this frame govern the next one
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < NC; c++) begin
            prev_d[s][c] = din_b[s][c];
            cm_m[s][c]   = ctl_b[s][c];
         end
   endtask

   task automatic check_idle(input string tag);
      checks++;
      if (ser_oe !== '0 || ser_out !== '0) begin
         failures++;
         $display("FAIL %s idle outputs: oe=%b out=%b expected oe=00 out=00", tag, ser_oe, ser_out);
      end
   endtask

   initial begin
      clear_model();
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: before any strobe, inputs full of ones must not land anywhere
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #1;
         ctrl_in = '1;
         data_in = '1;
         glob_oe = 1'b1;
         @(negedge clk);
         check_idle("R1");
      end
      // table walk; first frame must stay silent (R1, R9)
      for (int v = 0; v < NVEC; v++)
         run_frame(VEC[v][11], int'(VEC[v][10:8]), int'(VEC[v][7:0]));
      // R9: reset in the middle of a frame clears entries and data
      @(posedge clk); #1;
      frame_sync = 1'b0;
      repeat (100) @(posedge clk);
      #1 rst_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check_idle("R9");
      end
      @(posedge clk); #1 rst_n = 1'b1;
      clear_model();
      run_frame(1'b1, 5, 77);   // R9: all slots tristated
      run_frame(1'b1, 2, 91);   // R5 R6: switching resumes
      run_frame(1'b1, 0, 12);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule